// File: doc/BRIEF.md
# Single-Writer Program/Erase Arbiter with Suspend

This controller decides which array operations a banked flash array may run. Only one program or erase can occupy the write engine at any time. Reads are allowed in every bank except the one being written. An erase can be suspended so that a program can run in a different block. A program can be suspended so that reads can reach other words. Each suspended operation is later resumed.

Each cycle the controller takes one decoded command and its address. The address is split, from the top bit down, into a bank field, a block field and a word field. An external timing engine reports when an operation is finished and whether it failed. The controller tells that engine when to start a new operation and when to keep counting. For each read command it grants or refuses permission in the same cycle. An 8-bit status word reports readiness, the suspend states and the sticky error flags.

Top module: `pe_suspend_ctrl`

## Requirements
- R1: After reset, status reads 0x80 (ready, no suspend, no errors), `eng_run` is low and `busy_bank` is 0. The command codes are: 1 read, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear status. Status bits are: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 2 program suspended, 1 read conflict. Bits 3 and 0 are always 0.
- R2: A program or erase issued while idle raises `eng_start` in that cycle, with `eng_op` = 1 for erase and 0 for program. From the next cycle, ready (bit 7) is 0 and `busy_bank` holds the target bank.
- R3: A program or erase issued while any operation is running or suspended is refused, except for the case allowed by R6. A refused command gives no `eng_start` and sets status bit 4 (program) or bit 5 (erase).
- R4: While an operation is running, a read gets `rd_ok` in the same cycle only if its bank differs from the running bank. A refused read sets status bit 1.
- R5: A suspend issued during a running erase stops `eng_run` and gives status bit 6 = 1 and bit 7 = 1. A following resume returns to a running erase.
- R6: While an erase is suspended, a program to a block other than the suspended block is accepted and starts the engine. A program to the suspended block is refused with bit 4.
- R7: A resume issued while a program runs under a suspended erase is held pending. When that program completes, the erase runs again if a resume is pending. Otherwise the erase stays suspended.
- R8: A suspend issued during a running program gives status bit 2 = 1 and bit 7 = 1. Reads of any word other than the suspended word are permitted. Programs and erases are refused. A resume returns to a running program.
- R9: A completion with the error flag set gives bit 5 for an erase and bit 4 for a program. Error bits 5, 4 and 1 stay set until a clear-status command.
- R10: Suspend and resume have no effect when there is nothing to suspend or resume. This covers the idle state, an already suspended erase and a program running under a suspended erase (for suspend).
- R11: While an erase is suspended, a read of any word in the suspended block is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd | input | 3 | Command code (see R1) |
| cmd_addr | input | BANK_W+BLK_W+WORD_W | Address as {bank, block, word} |
| eng_done | input | 1 | Timing engine finished the running operation |
| eng_err | input | 1 | The finished operation failed (qualified by eng_done) |
| rd_ok | output | 1 | Current read command is permitted |
| eng_start | output | 1 | Start a new operation in the engine |
| eng_op | output | 1 | Operation being started: 1 erase, 0 program |
| eng_run | output | 1 | Engine should advance the running operation |
| busy_bank | output | BANK_W | Bank of the running or suspended operation |
| status | output | 8 | Status word (see R1) |

## Verification
A wrong internal state shows up at the ports on the next edge. Ready or a suspend bit in the status word disagrees with the expected value one cycle after the command that moved the state, and `busy_bank` names the wrong bank. A stored address that is wrong shows up only through read permission. For that reason the bench sweeps every address of the small configuration against each busy or suspended target and checks `rd_ok` combinationally in the same cycle. A lost pending resume shows up only at program completion, where status stays 0xC0 instead of going to 0x00.

// File: rtl/pe_suspend_ctrl.sv
module pe_suspend_ctrl #(
  parameter int BANK_W = 2,
  parameter int BLK_W  = 2,
  parameter int WORD_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  input  logic [2:0]                     cmd,
  input  logic [BANK_W+BLK_W+WORD_W-1:0] cmd_addr,
  input  logic                           eng_done,
  input  logic                           eng_err,
  output logic                           rd_ok,
  output logic                           eng_start,
  output logic                           eng_op,
  output logic                           eng_run,
  output logic [BANK_W-1:0]              busy_bank,
  output logic [7:0]                     status
);
  localparam int ADDR_W = BANK_W + BLK_W + WORD_W;
  localparam int BLKA_W = BANK_W + BLK_W;

  typedef enum logic [2:0] {S_IDLE, S_ERS, S_PRG, S_ESUS, S_PSUS, S_EPRG} st_t;

  st_t               st;
  logic              pend, err_e, err_p, err_r;
  logic [BLKA_W-1:0] ers_blk;
  logic [ADDR_W-1:0] prg_adr;

  wire running = (st == S_ERS) || (st == S_PRG) || (st == S_EPRG);
  wire esus    = (st == S_ESUS) || (st == S_EPRG);
  wire psus    = (st == S_PSUS);

  wire [BANK_W-1:0] ers_bank = ers_blk[BLKA_W-1 -: BANK_W];
  wire [BANK_W-1:0] prg_bank = prg_adr[ADDR_W-1 -: BANK_W];
  wire [BANK_W-1:0] run_bank = (st == S_ERS) ? ers_bank : prg_bank;
  wire [BANK_W-1:0] a_bank   = cmd_addr[ADDR_W-1 -: BANK_W];
  wire [BLKA_W-1:0] a_blk    = cmd_addr[ADDR_W-1 -: BLKA_W];

  wire is_rd = cmd_valid && cmd == 3'd1;
  wire is_pg = cmd_valid && cmd == 3'd2;
  wire is_er = cmd_valid && cmd == 3'd3;
  wire is_sp = cmd_valid && cmd == 3'd4;
  wire is_rs = cmd_valid && cmd == 3'd5;
  wire is_cl = cmd_valid && cmd == 3'd6;

  wire hit_run  = running && (a_bank == run_bank);
  wire hit_esus = esus && (a_blk == ers_blk);
  wire hit_psus = psus && (cmd_addr == prg_adr);

  wire pg_ok  = is_pg && ((st == S_IDLE) || (st == S_ESUS && !hit_esus));
  wire er_ok  = is_er && (st == S_IDLE);
  wire done_v = eng_done && running;

  assign rd_ok     = is_rd && !hit_run && !hit_esus && !hit_psus;
  assign eng_start = pg_ok || er_ok;
  assign eng_op    = er_ok;
  assign eng_run   = running;
  assign busy_bank = running ? run_bank :
                     (st == S_ESUS) ? ers_bank :
                     psus ? prg_bank : '0;
  assign status    = {!running, esus, err_e, err_p, 1'b0, psus, err_r, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      pend    <= 1'b0;
      err_e   <= 1'b0;
      err_p   <= 1'b0;
      err_r   <= 1'b0;
      ers_blk <= '0;
      prg_adr <= '0;
    end else begin
      if (done_v) begin
        case (st)
          S_ERS: begin
            st <= S_IDLE;
            if (eng_err) err_e <= 1'b1;
          end
          S_PRG: begin
            st <= S_IDLE;
            if (eng_err) err_p <= 1'b1;
          end
          default: begin
            st   <= pend ? S_ERS : S_ESUS;
            pend <= 1'b0;
            if (eng_err) err_p <= 1'b1;
          end
        endcase
      end else if (pg_ok) begin
        prg_adr <= cmd_addr;
        st      <= (st == S_IDLE) ? S_PRG : S_EPRG;
      end else if (er_ok) begin
        ers_blk <= a_blk;
        st      <= S_ERS;
      end else if (is_sp) begin
        if (st == S_ERS) st <= S_ESUS;
        else if (st == S_PRG) st <= S_PSUS;
      end else if (is_rs) begin
        if (st == S_ESUS) st <= S_ERS;
        else if (st == S_PSUS) st <= S_PRG;
        else if (st == S_EPRG) pend <= 1'b1;
      end

      if (is_cl) begin
        err_e <= 1'b0;
        err_p <= 1'b0;
        err_r <= 1'b0;
      end
      if (is_pg && !pg_ok) err_p <= 1'b1;
      if (is_er && !er_ok) err_e <= 1'b1;
      if (is_rd && !rd_ok) err_r <= 1'b1;
    end
  end

  // R2
  start_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> status[7]);

  // R2
  start_makes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start && !eng_done |=> !status[7]);

  // R4
  read_other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && eng_run |-> a_bank != busy_bank);

  // R9
  erase_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !is_cl |=> status[5]);

  // R9
  prog_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[4] && !is_cl |=> status[4]);

  // R7
  pending_resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] && !status[7] && !eng_done |=> status[6] && !status[7]);

  // R5
  suspend_stops_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] || status[2]) && status[7] |-> !eng_run);
endmodule

// File: tb/pe_suspend_ctrl_tb.sv
module pe_suspend_ctrl_tb_top;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic          eng_done = 1'b0;
  logic          eng_err = 1'b0;
  logic          rd_ok, eng_start, eng_op, eng_run;
  logic [1:0]    busy_bank;
  logic [7:0]    status;

  int  n_chk = 0;
  int  n_err = 0;
  logic s_rd, s_start, s_op;

  always #2 clk = ~clk;

  pe_suspend_ctrl #(.BANK_W(2), .BLK_W(2), .WORD_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .cmd_addr(cmd_addr),
    .eng_done(eng_done), .eng_err(eng_err), .rd_ok(rd_ok), .eng_start(eng_start),
    .eng_op(eng_op), .eng_run(eng_run), .busy_bank(busy_bank), .status(status));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_st(input int exp, input string req);
    chk(status == exp[7:0], req, status, exp);
  endtask

  task automatic issue(input int c, input int a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c[2:0]; cmd_addr = a[AW-1:0];
    #1;
    s_rd = rd_ok; s_start = eng_start; s_op = eng_op;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_op(input bit e);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  initial begin
    #800000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_st(8'h80, "R1 reset status");
    chk(!eng_run && busy_bank == 0, "R1 reset idle", {eng_run, busy_bank}, 0);

    for (int b = 0; b < 4; b++) begin
      issue(3, (b << 5) | (1 << 3));
      chk(s_start && s_op, "R2 erase start", {s_start, s_op}, 3);
      chk_st(8'h00, "R2 busy");
      chk(busy_bank == b, "R2 busy bank", busy_bank, b);
      issue(3, 0);
      chk(!s_start, "R3 erase refused", s_start, 0);
      chk_st(8'h20, "R3 erase error bit");
      issue(2, 0);
      chk(!s_start, "R3 program refused", s_start, 0);
      chk_st(8'h30, "R3 program error bit");
      issue(6, 0);
      for (int a = 0; a < 128; a++) begin
        issue(1, a);
        chk(s_rd == ((a >> 5) != b), "R4 read permit", s_rd, (a >> 5) != b);
      end
      chk_st(8'h02, "R4 read conflict bit");
      issue(6, 0);
      finish_op(1'b0);
      chk_st(8'h80, "R2 erase done");
    end

    issue(3, 8'h30);
    issue(4, 0);
    chk_st(8'hC0, "R5 erase suspended");
    chk(!eng_run, "R5 engine stopped", eng_run, 0);
    for (int a = 0; a < 128; a++) begin
      issue(1, a);
      chk(s_rd == ((a >> 3) != 6), "R11 suspended block read", s_rd, (a >> 3) != 6);
    end
    issue(6, 0);
    issue(4, 0);
    chk_st(8'hC0, "R10 second suspend ignored");
    issue(2, 8'h31);
    chk(!s_start, "R6 same block refused", s_start, 0);
    chk_st(8'hD0, "R6 program error");
    issue(6, 0);
    issue(2, 8'h50);
    chk(s_start && !s_op, "R6 program started", {s_start, s_op}, 2);
    chk_st(8'h40, "R6 program under suspend");
    chk(busy_bank == 2, "R6 busy bank", busy_bank, 2);
    issue(4, 0);
    chk_st(8'h40, "R10 suspend during nested program ignored");
    issue(5, 0);
    chk_st(8'h40, "R7 resume held");
    for (int a = 0; a < 128; a++) begin
      issue(1, a);
      chk(s_rd == (((a >> 5) != 2) && ((a >> 3) != 6)), "R4 nested read permit",
          s_rd, ((a >> 5) != 2) && ((a >> 3) != 6));
    end
    issue(6, 0);
    finish_op(1'b0);
    chk_st(8'h00, "R7 erase resumed after program");
    chk(busy_bank == 1, "R7 erase bank", busy_bank, 1);
    finish_op(1'b0);
    chk_st(8'h80, "R7 erase done");

    issue(3, 8'h08);
    issue(4, 0);
    issue(2, 8'h60);
    finish_op(1'b0);
    chk_st(8'hC0, "R7 no pending resume");
    issue(5, 0);
    chk_st(8'h00, "R5 resume erase");
    finish_op(1'b1);
    chk_st(8'hA0, "R9 erase error");
    issue(1, 0);
    chk_st(8'hA0, "R9 erase error sticky");
    issue(6, 0);
    chk_st(8'h80, "R9 clear");

    issue(4, 0);
    chk_st(8'h80, "R10 suspend idle");
    issue(5, 0);
    chk_st(8'h80, "R10 resume idle");

    issue(2, 8'h45);
    chk(s_start && !s_op, "R2 program start", {s_start, s_op}, 2);
    issue(4, 0);
    chk_st(8'h84, "R8 program suspended");
    chk(busy_bank == 2, "R8 busy bank", busy_bank, 2);
    for (int a = 0; a < 128; a++) begin
      issue(1, a);
      chk(s_rd == (a != 8'h45), "R8 read permit", s_rd, a != 8'h45);
    end
    issue(6, 0);
    issue(3, 0);
    chk(!s_start, "R8 erase refused", s_start, 0);
    chk_st(8'hA4, "R8 erase error");
    issue(2, 8'h10);
    chk_st(8'hB4, "R8 program error");
    issue(6, 0);
    issue(5, 0);
    chk_st(8'h00, "R8 resume program");
    finish_op(1'b1);
    chk_st(8'h90, "R9 program error");
    issue(5, 0);
    chk_st(8'h90, "R9 sticky after resume");
    issue(6, 0);
    chk_st(8'h80, "R9 cleared");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule